// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps two flags per external interrupt line: one that says a request is waiting, and one that says its handler is running. Each line is set up as pulse-sensitive or level-sensitive with a plain configuration input. A pulse line latches a request on the rising edge of its request pin. A level line latches a request whenever the pin is high and no handler for that line is running.

The pending line with the highest priority is offered on a valid/ready handshake. `req_valid` is high whenever any line is pending, and `req_id` names the lowest-numbered pending line. When the handler side asserts `req_ready` in a cycle where `req_valid` is high, that line is accepted. Its pending flag clears and its active flag sets on the next edge.

Back-pressure works as follows. The offer stays up for as long as `req_ready` is low. While the offer waits, `req_id` can move to a lower-numbered line that becomes pending. `req_ready` has no effect while `req_valid` is low. A separate exit strobe with a line index marks the end of a handler.

Top module: `irq_pend_tracker`

## Requirements
- R1: Synchronous reset (`rst_n` low at an edge) clears every pending and active flag, and `req_valid` is low after that edge.
- R2: On a line with `line_level` bit = 0 (pulse mode), a request pin that rises and stays high for even one cycle sets that line's pending flag at the next edge. A pin that is held high sets the flag only once.
- R3: On a pulse line, a rising edge that arrives while the line is already pending has no effect. It is neither counted nor queued, so a second activation finds nothing pending.
- R4: An accepted offer (`req_valid` and `req_ready` high together) clears the pending flag of line `req_id` and sets its active flag at the next edge. `req_ready` with `req_valid` low changes nothing.
- R5: While a line is active with its pending flag clear, a new rising edge on a pulse line sets pending again, so the line is pending and active at once.
- R6: On a line with `line_level` bit = 1 (level mode), a high request pin sets pending while the line is not active. While that line is active and not exiting, a high pin does not set pending.
- R7: If a level line's request pin is high in the cycle its exit strobe is given, the line is pending after that edge. If the pin is low, it is not.
- R8: `exit_valid` with `exit_id` clears that line's active flag at the next edge. An exit for a line that is not active changes nothing.
- R9: `req_valid` equals the OR of all pending flags, and `req_id` is the lowest index whose pending flag is set. Both follow the pending flags within the same cycle.
- R10: The line count `NUM_LINES` is a parameter, supported at 1 and 16. Index ports are max(1, clog2(`NUM_LINES`)) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_level | input | NUM_LINES | Per-line mode: 1 level, 0 pulse |
| line_req | input | NUM_LINES | Raw interrupt request pins |
| req_valid | output | 1 | A pending line is being offered |
| req_ready | input | 1 | Handler side accepts the offered line |
| req_id | output | IDW | Index of the offered line |
| exit_valid | input | 1 | Handler return strobe |
| exit_id | input | IDW | Line whose handler returns |
| pending | output | NUM_LINES | Pending flags |
| active | output | NUM_LINES | Active flags |

## Verification
Pending and active flags are registers. Any request, acceptance, exit or reset applied in one cycle therefore shows up in those flags exactly one edge later. `req_valid` and `req_id` are decoded from the registered pending flags, so they move in the same cycle as those flags. Each stimulus is driven just after a rising edge, and its expected snapshot is queued at the same moment. The monitor pops that snapshot one nanosecond after the following edge and compares all four outputs there. This keeps every comparison exactly one register stage behind its stimulus.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_LEVEL = 1'b1
  } line_mode_e;

  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_mode_e mode,
  input  logic       req,
  input  logic       take,
  input  logic       leave,
  output logic       pend,
  output logic       act
);

  logic req_q, pend_q, act_q;
  logic rise, set_req, pend_d, act_d;

  assign rise = req & ~req_q;

  always_comb begin
    if (mode == MODE_LEVEL) set_req = req & (~act_q | leave);
    else                    set_req = rise;
    // an assertion while already pending is dropped; acceptance clears
    pend_d = pend_q ? ~take : set_req;
    act_d  = (act_q & ~leave) | take;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend = pend_q;
  assign act  = act_q;

  AST_TAKE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend_q); // R4
  AST_TAKE_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> act_q); // R4
  AST_LEAVE_CLEARS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && !take) |=> !act_q); // R8
  AST_PULSE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE && $rose(req) && !pend_q) |=> pend_q); // R2
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> pend_q); // R3
  AST_LEVEL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEVEL && act_q && !leave && !pend_q) |=> !pend_q); // R6
  AST_LEVEL_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEVEL && act_q && leave && req) |=> pend_q); // R7

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NL  = 16,
  parameter int IDW = 4
) (
  input  logic [NL-1:0]  pend_vec,
  output logic           any,
  output logic [IDW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pend_vec[i]) idx = IDW'(i);
    end
  end

  assign any = |pend_vec;

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDW = id_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_level,
  input  logic [NUM_LINES-1:0] line_req,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [IDW-1:0]       req_id,
  input  logic                 exit_valid,
  input  logic [IDW-1:0]       exit_id,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] active
);

  logic                 accept;
  logic [NUM_LINES-1:0] take_vec, leave_vec;

  assign accept = req_valid & req_ready;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign take_vec[g]  = accept && (req_id == IDW'(g));
    assign leave_vec[g] = exit_valid && (exit_id == IDW'(g));

    irq_line_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (line_mode_e'(line_level[g])),
      .req   (line_req[g]),
      .take  (take_vec[g]),
      .leave (leave_vec[g]),
      .pend  (pending[g]),
      .act   (active[g])
    );
  end

  irq_prio_pick #(.NL(NUM_LINES), .IDW(IDW)) u_pick (
    .pend_vec (pending),
    .any      (req_valid),
    .idx      (req_id)
  );

  AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> pending[req_id]); // R9
  AST_OFFER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pending & ((NUM_LINES'(1) << req_id) - NUM_LINES'(1))) == '0)); // R9
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (pending == '0)); // R9
  AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec)); // R4

endmodule

// File: tb/irq_pend_tracker_tb.sv
module irq_pend_tracker_tb_top;

  localparam int NL  = 16;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] line_level = 16'hFF00;
  logic [NL-1:0] line_req = '0;
  logic req_ready = 1'b0, exit_valid = 1'b0;
  logic [IDW-1:0] exit_id = '0;
  logic req_valid;
  logic [IDW-1:0] req_id;
  logic [NL-1:0] pending, active;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_pend_tracker #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_level(line_level), .line_req(line_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .exit_valid(exit_valid), .exit_id(exit_id),
    .pending(pending), .active(active)
  );

  typedef struct {
    logic [NL-1:0]  p;
    logic [NL-1:0]  a;
    logic           v;
    logic [IDW-1:0] id;
    string          tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;

  function automatic logic [IDW-1:0] low_idx(input logic [NL-1:0] m);
    for (int i = 0; i < NL; i++) if (m[i]) return IDW'(i);
    return '0;
  endfunction

  task automatic step(input logic [NL-1:0] r, input logic rdy, input logic ev,
                      input int eid, input logic rst, input logic [NL-1:0] ep,
                      input logic [NL-1:0] ea, input string tag);
    exp_t e;
    @(posedge clk); #2;
    line_req = r; req_ready = rdy; exit_valid = ev; exit_id = IDW'(eid); rst_n = ~rst;
    e.p = ep; e.a = ea; e.v = |ep; e.id = low_idx(ep); e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      n_cmp++;
      if (pending !== cur.p || active !== cur.a || req_valid !== cur.v ||
          (cur.v && req_id !== cur.id)) begin
        n_bad++;
        $display("FAIL %s: got p=%h a=%h v=%b id=%0d exp p=%h a=%h v=%b id=%0d",
                 cur.tag, pending, active, req_valid, req_id,
                 cur.p, cur.a, cur.v, cur.id);
      end
    end
  end

  initial begin
    step('0, 0, 0, 0, 1, '0, '0, "R1 reset state");
    step(16'h0004, 0, 0, 0, 0, 16'h0004, '0, "R2 one pulse edge pends");
    step(16'h0004, 0, 0, 0, 0, 16'h0004, '0, "R2 held high stays pending");
    step(16'h0004, 1, 0, 0, 0, '0, 16'h0004, "R4 accept line 2");
    step(16'h0004, 0, 0, 0, 0, '0, 16'h0004, "R2 held high no re-pend");
    step(16'h0000, 0, 0, 0, 0, '0, 16'h0004, "R5 pin drops");
    step(16'h0004, 0, 0, 0, 0, 16'h0004, 16'h0004, "R5 pending while active");
    step(16'h0000, 0, 0, 0, 0, 16'h0004, 16'h0004, "R3 pin drops");
    step(16'h0004, 0, 0, 0, 0, 16'h0004, 16'h0004, "R3 edge while pending");
    step(16'h0000, 1, 0, 0, 0, '0, 16'h0004, "R3 accept again");
    step(16'h0000, 0, 0, 0, 0, '0, 16'h0004, "R3 dropped edge not queued");
    step(16'h0000, 0, 1, 2, 0, '0, '0, "R8 exit line 2");
    step(16'h0000, 0, 1, 5, 0, '0, '0, "R8 exit idle line ignored");
    step(16'h0100, 0, 0, 0, 0, 16'h0100, '0, "R6 level pends");
    step(16'h0100, 1, 0, 0, 0, '0, 16'h0100, "R4 accept level line 8");
    step(16'h0100, 0, 0, 0, 0, '0, 16'h0100, "R6 level blocked while active");
    step(16'h0100, 0, 1, 8, 0, 16'h0100, '0, "R7 exit with pin high re-pends");
    step(16'h0000, 1, 0, 0, 0, '0, 16'h0100, "R7 accept re-pended line");
    step(16'h0000, 0, 1, 8, 0, '0, '0, "R7 exit with pin low no re-pend");
    step(16'h0120, 0, 0, 0, 0, 16'h0120, '0, "R9 two pend, lowest offered");
    step(16'h0120, 1, 0, 0, 0, 16'h0100, 16'h0020, "R9 accept line 5");
    step(16'h0101, 0, 0, 0, 0, 16'h0101, 16'h0020, "R9 line 0 overtakes");
    step(16'h0100, 1, 0, 0, 0, 16'h0100, 16'h0021, "R9 accept line 0");
    step(16'h0000, 1, 0, 0, 0, '0, 16'h0121, "R4 accept line 8");
    step(16'h0000, 0, 1, 0, 0, '0, 16'h0120, "R8 exit line 0");
    step(16'h0000, 0, 1, 5, 0, '0, 16'h0100, "R8 exit line 5");
    step(16'h0000, 1, 1, 8, 0, '0, '0, "R4 ready without valid ignored");
    step(16'h0010, 0, 0, 0, 0, 16'h0010, '0, "R10 line 4 pends");
    step(16'h0010, 1, 0, 0, 0, '0, 16'h0010, "R10 accept line 4");
    step(16'h0000, 0, 0, 0, 0, '0, 16'h0010, "R10 line 4 active");
    step(16'h0010, 0, 0, 0, 1, '0, '0, "R1 reset mid-run");
    step(16'h0000, 0, 0, 0, 0, '0, '0, "R1 stays clear");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule